// File: doc/BRIEF.md
# Flash Data-Polling Status Controller

This block sits on the host side of a parallel NOR flash. It waits for the flash to finish an embedded program or erase, and it judges the outcome from the bit-7 status output alone. Software or a command sequencer pulses `start_i` with four inputs: the operation kind, the target address, the expected datum and a cycle limit. The block holds the request until the sequencer reports that the last write pulse of the command sequence has completed. After that it issues single-beat reads to the target address through a request/valid port.

For a program, the flash reports busy by returning the complement of the programmed bit 7. For an erase, it reports busy with a 0 on bit 7. Once bit 7 shows completion, the controller takes that read as a hint only, because the low bits may still be in transition. It then issues one more read and judges the result from that later word.

A program passes only when the confirming word equals the expected datum in every bit. An erase passes when the confirming read still shows a 1 on bit 7. A program aimed at a protected sector falls back to read mode with the old contents, so it ends as a failure. An erase whose sectors are all protected never shows completion and ends on the cycle limit. Each outcome is a single-cycle pulse, and the controller is then idle again.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `fail_o`, `timeout_o` and `rd_req_o` are low until a start is accepted.
- R2: After an accepted start, no read request is issued until `wr_done_i` has been seen high, and the cycle limit does not run while waiting for it.
- R3: A read request is a one-cycle `rd_req_o` pulse with `rd_addr_o` equal to the address captured at start. No further request is issued until `rd_valid_i` answers it, and read data is sampled only in a cycle where `rd_valid_i` is high.
- R4: For a program (`op_erase_i`=0), a poll read shows completion when its bit 7 equals bit 7 of the expected datum. Reads whose bit 7 is the complement cause another poll read.
- R5: For an erase (`op_erase_i`=1), a poll read shows completion when bit 7 is 1. Reads with bit 7 equal to 0 cause another poll read.
- R6: After completion is seen, one further read is issued. For a program, `done_o` pulses if that word equals the expected datum in all 8 bits, and `fail_o` pulses otherwise. The completion read's low bits are never used.
- R7: For an erase, `done_o` pulses if the confirming read has bit 7 equal to 1, and `fail_o` pulses otherwise.
- R8: With limit L on `tmo_limit_i`, polling starts in the cycle after `wr_done_i` is sampled. If no result is reached, `timeout_o` is high in the (L+1)-th cycle after that sampling edge. A confirming response that arrives in the expiry cycle is judged as a result instead of timing out.
- R9: `done_o`, `fail_o` and `timeout_o` are mutually exclusive one-cycle pulses. No read request follows a pulse, and a new start is accepted right afterwards.
- R10: A start pulse while an operation is in progress is ignored. Operation kind, address and datum stay as captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_erase_i | input | 1 | 0 = program, 1 = erase |
| addr_i | input | ADDR_W | Address to poll |
| data_i | input | DATA_W | Expected programmed datum |
| tmo_limit_i | input | TMO_W | Polling cycle limit L |
| wr_done_i | input | 1 | Final write pulse of command sequence finished |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data |
| done_o | output | 1 | Success pulse |
| fail_o | output | 1 | Protected or failed pulse |
| timeout_o | output | 1 | Timeout pulse |

## Verification
The confirming read's response and the expiry of the cycle limit can land in the same cycle. The bench provokes this with an immediately completing program and a limit of 3, so that the confirming response arrives exactly at expiry, and it expects `done_o` four cycles after the `wr_done_i` sampling edge. A limit of 2 makes expiry fall one cycle earlier, and there `timeout_o` is expected in the third cycle. This pins down the precedence from both sides.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_POLL,
    ST_CONF,
    ST_DONE,
    ST_ERR
  } fpoll_state_e;
endpackage

// File: rtl/fpoll_timer.sv
module fpoll_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge #(
  parameter int DATA_W   = 8,
  parameter int STAT_BIT = DATA_W - 1
) (
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              bit_done_o,
  output logic              word_ok_o
);
  logic stat;
  assign stat = rdata_i[STAT_BIT];

  always_comb begin
    if (op_erase_i) begin
      bit_done_o = stat;
      word_ok_o  = stat;
    end else begin
      bit_done_o = (stat == exp_i[STAT_BIT]);
      word_ok_o  = (rdata_i == exp_i);
    end
  end
endmodule

// File: rtl/fpoll_fsm.sv
module fpoll_fsm
  import fpoll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wr_done_i,
  input  logic rd_valid_i,
  input  logic bit_done_i,
  input  logic word_ok_i,
  input  logic expired_i,
  output logic accept_o,
  output logic run_o,
  output logic rd_req_o,
  output logic done_o,
  output logic fail_o,
  output logic timeout_o
);
  fpoll_state_e st_q, st_d;
  logic pend_q, pend_d;
  logic tmo_q, tmo_d;
  logic got;

  assign run_o    = (st_q == ST_POLL) || (st_q == ST_CONF);
  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign rd_req_o = run_o && !pend_q && !expired_i;
  assign got      = rd_valid_i && pend_q;

  always_comb begin
    st_d  = st_q;
    tmo_d = tmo_q;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_WAIT;
      ST_WAIT: if (wr_done_i) st_d = ST_POLL;
      ST_POLL: begin
        if (expired_i) begin
          st_d  = ST_ERR;
          tmo_d = 1'b1;
        end else if (got && bit_done_i) begin
          st_d = ST_CONF;
        end
      end
      ST_CONF: begin
        if (got) begin
          if (word_ok_i) st_d = ST_DONE;
          else begin
            st_d  = ST_ERR;
            tmo_d = 1'b0;
          end
        end else if (expired_i) begin
          st_d  = ST_ERR;
          tmo_d = 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (!run_o)          pend_d = 1'b0;
    else if (rd_req_o)   pend_d = 1'b1;
    else if (rd_valid_i) pend_d = 1'b0;
    else                 pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      tmo_q  <= tmo_d;
    end
  end

  assign done_o    = (st_q == ST_DONE);
  assign fail_o    = (st_q == ST_ERR) && !tmo_q;
  assign timeout_o = (st_q == ST_ERR) && tmo_q;
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8,
  parameter int TMO_W    = 16,
  parameter int STAT_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              wr_done_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o
);
  logic              accept, run, expired, bit_done, word_ok;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TMO_W-1:0]  limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      limit_q <= '0;
    end else if (accept) begin
      op_q    <= op_erase_i;
      addr_q  <= addr_i;
      data_q  <= data_i;
      limit_q <= tmo_limit_i;
    end
  end

  assign rd_addr_o = addr_q;

  fpoll_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wr_done_i  (wr_done_i),
    .rd_valid_i (rd_valid_i),
    .bit_done_i (bit_done),
    .word_ok_i  (word_ok),
    .expired_i  (expired),
    .accept_o   (accept),
    .run_o      (run),
    .rd_req_o   (rd_req_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .timeout_o  (timeout_o)
  );

  fpoll_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .limit_i   (limit_q),
    .expired_o (expired)
  );

  fpoll_judge #(.DATA_W(DATA_W), .STAT_BIT(STAT_BIT)) u_judge (
    .op_erase_i (op_q),
    .exp_i      (data_q),
    .rdata_i    (rd_data_i),
    .bit_done_o (bit_done),
    .word_ok_o  (word_ok)
  );
endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_done_i,
  input logic rd_req_o,
  input logic done_o,
  input logic fail_o,
  input logic timeout_o
);
  logic seen_wr_q;
  logic any_res;
  assign any_res = done_o || fail_o || timeout_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_wr_q <= 1'b0;
    else if (any_res)   seen_wr_q <= 1'b0;
    else if (wr_done_i) seen_wr_q <= 1'b1;
  end

  assert_req_after_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> seen_wr_q);
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fail_o, timeout_o}));
  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_res |=> !any_res);
  assert_quiet_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_res |=> !rd_req_o);
endmodule

bind flash_poll_ctrl fpoll_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_done_i (wr_done_i),
  .rd_req_o  (rd_req_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .timeout_o (timeout_o)
);

// File: tb/tb_flash_poll_ctrl.sv
module tb_flash_poll_ctrl;
  localparam int AW = 24, DW = 8, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, op_erase_i = 0, wr_done_i = 0, rd_valid_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0, rd_data_i = '0;
  logic [TW-1:0] tmo_limit_i = '0;
  logic rd_req_o, done_o, fail_o, timeout_o;
  logic [AW-1:0] rd_addr_o;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .addr_i(addr_i), .data_i(data_i), .tmo_limit_i(tmo_limit_i),
    .wr_done_i(wr_done_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .done_o(done_o),
    .fail_o(fail_o), .timeout_o(timeout_o));

  int n_chk = 0, n_bad = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // op, datum, busy reads, final word, garble (1: early bit7, 2: erase relapse), limit, expected
  typedef struct packed {
    logic        op;
    logic [7:0]  datum;
    logic [15:0] busy;
    logic [7:0]  fin;
    logic [1:0]  garble;
    logic [15:0] limit;
    logic [1:0]  res;   // 0 done, 1 fail, 2 timeout
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hA5, 16'd3,    8'hA5, 2'd0, 16'd1000, 2'd0},
    '{1'b0, 8'h3C, 16'd5,    8'h3C, 2'd0, 16'd1000, 2'd0},
    '{1'b0, 8'hA5, 16'd2,    8'hA5, 2'd1, 16'd1000, 2'd0},
    '{1'b0, 8'hA5, 16'd4,    8'h80, 2'd0, 16'd1000, 2'd1},
    '{1'b1, 8'h00, 16'd6,    8'hFF, 2'd0, 16'd1000, 2'd0},
    '{1'b1, 8'h00, 16'd6,    8'hFF, 2'd2, 16'd1000, 2'd1},
    '{1'b1, 8'h00, 16'd1000, 8'h12, 2'd0, 16'd200,  2'd2},
    '{1'b0, 8'h5A, 16'd1000, 8'h5A, 2'd0, 16'd50,   2'd2},
    '{1'b0, 8'h12, 16'd0,    8'h12, 2'd0, 16'd1000, 2'd0}
  };

  // flash model state
  logic       m_op;
  logic [7:0] m_datum, m_fin;
  int         m_busy, m_garble, m_k;
  logic [AW-1:0] m_addr;
  int  addr_err, early_req;
  logic armed, resp_pend;

  function automatic logic [7:0] model_word(int k);
    logic [7:0] bw;
    bw = m_op ? 8'h00 : {~m_datum[7], m_datum[6:0] ^ 7'h55};
    if (k < m_busy) return bw;
    if (k == m_busy && m_garble == 1) return {m_fin[7], ~m_fin[6:0]};
    if (k == m_busy + 1 && m_garble == 2) return bw;
    return m_fin;
  endfunction

  initial begin
    resp_pend = 0;
    forever begin
      @(negedge clk);
      rd_valid_i = 1'b0;
      if (resp_pend) begin
        rd_valid_i = 1'b1;
        rd_data_i  = model_word(m_k);
        m_k++;
        resp_pend = 0;
      end
      if (rd_req_o) begin
        resp_pend = 1;
        if (rd_addr_o != m_addr) addr_err++;
        if (!armed) early_req++;
      end
    end
  end

  task automatic setup_model(logic op, logic [7:0] d, int busy, logic [7:0] fin,
                             int garble, logic [AW-1:0] a);
    m_op = op; m_datum = d; m_busy = busy; m_fin = fin; m_garble = garble;
    m_addr = a; m_k = 0; addr_err = 0; early_req = 0; armed = 0;
  endtask

  task automatic do_start(logic op, logic [7:0] d, logic [AW-1:0] a, logic [TW-1:0] lim);
    @(negedge clk);
    start_i = 1; op_erase_i = op; data_i = d; addr_i = a; tmo_limit_i = lim;
    @(negedge clk);
    start_i = 0; op_erase_i = 0; data_i = '0; addr_i = '0; tmo_limit_i = '0;
  endtask

  // drives wr_done for one cycle; returns right after the sampling edge
  task automatic do_wr_done();
    @(negedge clk);
    wr_done_i = 1; armed = 1;
    @(posedge clk);
    #1 wr_done_i = 0;
  endtask

  // counts cycles after the wr_done sampling edge until a result shows
  task automatic wait_res(int maxc, output int res, output int cyc);
    res = 3; cyc = 0;
    for (int j = 1; j <= maxc; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_o || fail_o || timeout_o) begin
        res = done_o ? 0 : (fail_o ? 1 : 2);
        cyc = j;
        chk("R9 exclusive", int'(done_o) + int'(fail_o) + int'(timeout_o), 1);
        break;
      end
    end
    @(negedge clk);
    chk("R9 one-cycle pulse", int'(done_o | fail_o | timeout_o), 0);
    chk("R9 no request after result", int'(rd_req_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int res, cyc;
    setup_model(0, 8'h00, 0, 8'h00, 0, '0);
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", int'({rd_req_o, done_o, fail_o, timeout_o}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 outputs after reset", int'({rd_req_o, done_o, fail_o, timeout_o}), 0);

    // vector table: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      setup_model(VECS[v].op, VECS[v].datum, int'(VECS[v].busy), VECS[v].fin,
                  int'(VECS[v].garble), 24'h010000 + 24'(v * 16'h0101));
      do_start(VECS[v].op, VECS[v].datum, 24'h010000 + 24'(v * 16'h0101), VECS[v].limit);
      repeat (2) @(negedge clk);
      do_wr_done();
      wait_res(int'(VECS[v].limit) + 50, res, cyc);
      $display("vector %0d: result %0d after %0d cycles", v, res, cyc);
      chk("R4/R5/R6/R7/R8 vector result", res, int'(VECS[v].res));
      chk("R3 request address", addr_err, 0);
      repeat (4) @(negedge clk);
    end

    // R2: no reads before wr_done, timer idle while waiting
    setup_model(0, 8'hC3, 0, 8'hC3, 0, 24'h00ABCD);
    do_start(0, 8'hC3, 24'h00ABCD, 16'd3);
    repeat (12) @(negedge clk);
    do_wr_done();
    wait_res(20, res, cyc);
    chk("R2 no request before wr_done", early_req, 0);
    chk("R2 timer idle while waiting", res, 0);
    repeat (4) @(negedge clk);

    // R8: precise timeout cycle, limit 20, never completes
    setup_model(0, 8'h66, 100000, 8'h66, 0, 24'h000100);
    do_start(0, 8'h66, 24'h000100, 16'd20);
    do_wr_done();
    wait_res(100, res, cyc);
    chk("R8 timeout result", res, 2);
    chk("R8 timeout cycle L+1", cyc, 21);
    repeat (4) @(negedge clk);

    // R8: confirming response in the expiry cycle wins (limit 3)
    setup_model(0, 8'hA5, 0, 8'hA5, 0, 24'h000200);
    do_start(0, 8'hA5, 24'h000200, 16'd3);
    do_wr_done();
    wait_res(20, res, cyc);
    chk("R8 response at expiry judged", res, 0);
    chk("R8 done cycle", cyc, 4);
    repeat (4) @(negedge clk);

    // R8: expiry one cycle before confirming response (limit 2)
    setup_model(0, 8'hA5, 0, 8'hA5, 0, 24'h000300);
    do_start(0, 8'hA5, 24'h000300, 16'd2);
    do_wr_done();
    wait_res(20, res, cyc);
    chk("R8 expiry before response", res, 2);
    chk("R8 expiry cycle", cyc, 3);
    repeat (4) @(negedge clk);

    // R10: start while busy ignored
    setup_model(0, 8'hA5, 10, 8'hA5, 0, 24'h000400);
    do_start(0, 8'hA5, 24'h000400, 16'd1000);
    do_wr_done();
    repeat (3) @(negedge clk);
    start_i = 1; op_erase_i = 1; data_i = 8'h00; addr_i = 24'h777777; tmo_limit_i = 16'd1;
    @(negedge clk);
    start_i = 0; op_erase_i = 0; data_i = '0; addr_i = '0; tmo_limit_i = '0;
    wait_res(200, res, cyc);
    chk("R10 start ignored: result", res, 0);
    chk("R10 start ignored: address", addr_err, 0);
    repeat (4) @(negedge clk);

    // R1: reset in the middle of polling
    setup_model(0, 8'h11, 100000, 8'h11, 0, 24'h000500);
    do_start(0, 8'h11, 24'h000500, 16'd1000);
    do_wr_done();
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset mid-poll", int'({rd_req_o, done_o, fail_o, timeout_o}), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R1 idle after reset", int'({rd_req_o, done_o, fail_o, timeout_o}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule